// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block brings a CAN-style controller from the bus-off state back to error-active. It samples the bus one bit at a time. A bit is taken only on cycles where a bit-valid strobe is high. The block counts runs of consecutive recessive bits, and for each completed run of eleven it lowers the transmit error counter by one. The counter is loaded with 127 when bus-off is entered. The first detected run after the counter has reached zero ends recovery. That makes 128 detected runs from entry to error-active.

Software gates the process with a reset-mode control bit. While that bit is 1 no progress is made. Recovery starts only once the bit is written to 0. At the end of recovery the bus-off flag drops by itself, and the block raises a single-cycle error-warning interrupt. Outside bus-off the block passes the externally maintained error counter through, one register stage late.

Top module: `can_busoff_recovery`

## Requirements
- R1: After reset, `tec_out` is 0, `busoff_flag` is 0 and `warn_irq` is 0.
- R2: A high `busoff_set` in a cycle makes `busoff_flag` 1 and `tec_out` 127 on the next cycle. This holds whatever the other inputs are, including during a recovery already in progress, and any partial recessive run is discarded.
- R3: In bus-off with `sw_reset_mode` = 1, `tec_out` does not change and the recessive-run count is cleared. Recessive bits seen before the reset-mode cycle therefore do not count toward a later run.
- R4: In bus-off with `sw_reset_mode` = 0, eleven consecutive valid recessive samples (`rx_bit` = 1) lower `tec_out` by exactly one. The new value is visible on the cycle after the eleventh sample.
- R5: A valid dominant sample (`rx_bit` = 0) restarts the run count at zero. Cycles with `rx_bit_valid` = 0 neither extend nor break a run.
- R6: After a run of eleven is counted, counting restarts at zero. 21 consecutive recessive samples give one decrement, and 22 give two.
- R7: A completed run while `tec_out` is 0 clears `busoff_flag` on the next cycle with no software action. From entry this takes 128 runs (1408 recessive samples with no break).
- R8: `warn_irq` is high for exactly one cycle. That is the first cycle in which `busoff_flag` reads 0 after recovery ends, and `warn_irq` is low at all other times.
- R9: While not in bus-off, `tec_out` equals the `tec_in` value of the previous cycle, and the bit stream has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit_valid | input | 1 | Qualifies `rx_bit` for this cycle |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| busoff_set | input | 1 | Bus-off entry event (one cycle) |
| sw_reset_mode | input | 1 | Software reset-mode bit; 1 holds recovery |
| tec_in | input | TEC_W (9) | Error counter value maintained outside bus-off |
| tec_out | output | TEC_W (9) | Current transmit error counter |
| busoff_flag | output | 1 | Bus-off status |
| warn_irq | output | 1 | Error-warning interrupt pulse at end of recovery |

## Verification
The assertions assume that `busoff_set` is a short event that is never asserted in the same cycle recovery finishes. They also assume that `tec_in` is meaningful only outside bus-off, and that `rx_bit` is ignored whenever `rx_bit_valid` is low. The random stimulus issues entry pulses rarely, so most recoveries run long enough to exercise decrements, reset-mode toggles and dominant breaks. It keeps recessive bits heavily weighted so that runs of eleven occur often. Directed sequences cover the exact 1408-sample drain, the run boundaries at 10, 11, 21 and 22 samples, and re-entry during recovery.

// File: rtl/can_bor_pkg.sv
package can_bor_pkg;

  localparam int unsigned RUN_LEN_DEF   = 11;
  localparam int unsigned TEC_W_DEF     = 9;
  localparam int unsigned TEC_START_DEF = 127;

  typedef enum logic [1:0] {
    RUN_KEEP  = 2'd0,
    RUN_CLEAR = 2'd1,
    RUN_INC   = 2'd2,
    RUN_WRAP  = 2'd3
  } run_act_e;

  // Decide what the recessive-run counter does this cycle.
  function automatic run_act_e run_action(input logic hold, input logic valid,
                                          input logic recessive, input logic at_last);
    if (hold)       return RUN_CLEAR;
    if (!valid)     return RUN_KEEP;
    if (!recessive) return RUN_CLEAR;
    if (at_last)    return RUN_WRAP;
    return RUN_INC;
  endfunction

  // Recovery is finished by a run seen while the counter is already at zero.
  function automatic logic recovery_done(input logic in_busoff, input logic run_hit,
                                         input logic tec_zero);
    return in_busoff & run_hit & tec_zero;
  endfunction

endpackage

// File: rtl/can_bor_run_det.sv
module can_bor_run_det
  import can_bor_pkg::*;
#(
  parameter int unsigned RUN_LEN = RUN_LEN_DEF,
  localparam int unsigned RUN_W  = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             bit_valid,
  input  logic             bus_bit,
  output logic [RUN_W-1:0] run_cnt,
  output logic             run_done
);

  localparam logic [RUN_W-1:0] LAST = RUN_W'(RUN_LEN - 1);

  run_act_e act;

  always_comb begin
    act      = run_action(hold, bit_valid, bus_bit, run_cnt == LAST);
    run_done = (act == RUN_WRAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else begin
      unique case (act)
        RUN_CLEAR, RUN_WRAP: run_cnt <= '0;
        RUN_INC:             run_cnt <= run_cnt + 1'b1;
        default:             run_cnt <= run_cnt;
      endcase
    end
  end

endmodule

// File: rtl/can_bor_tec.sv
module can_bor_tec
  import can_bor_pkg::*;
#(
  parameter int unsigned TEC_W     = TEC_W_DEF,
  parameter int unsigned TEC_START = TEC_START_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_start,
  input  logic             in_busoff,
  input  logic             step,
  input  logic [TEC_W-1:0] tec_in,
  output logic [TEC_W-1:0] tec_q,
  output logic             at_zero
);

  localparam logic [TEC_W-1:0] START_VAL = TEC_W'(TEC_START);

  assign at_zero = (tec_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
    end else if (load_start) begin
      tec_q <= START_VAL;
    end else if (!in_busoff) begin
      tec_q <= tec_in;
    end else if (step && !at_zero) begin
      tec_q <= tec_q - 1'b1;
    end
  end

endmodule

// File: rtl/can_bor_status.sv
module can_bor_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic done_evt,
  output logic busoff_q,
  output logic warn_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busoff_q <= 1'b0;
      warn_q   <= 1'b0;
    end else begin
      warn_q <= done_evt & ~set_evt;
      if (set_evt)       busoff_q <= 1'b1;
      else if (done_evt) busoff_q <= 1'b0;
    end
  end

endmodule

// File: rtl/can_busoff_recovery.sv
module can_busoff_recovery
  import can_bor_pkg::*;
#(
  parameter int unsigned RUN_LEN   = RUN_LEN_DEF,
  parameter int unsigned TEC_W     = TEC_W_DEF,
  parameter int unsigned TEC_START = TEC_START_DEF,
  localparam int unsigned RUN_W    = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit_valid,
  input  logic             rx_bit,
  input  logic             busoff_set,
  input  logic             sw_reset_mode,
  input  logic [TEC_W-1:0] tec_in,
  output logic [TEC_W-1:0] tec_out,
  output logic             busoff_flag,
  output logic             warn_irq
);

  // Named internal events, brought out for the checker.
  logic             run_hold;
  logic [RUN_W-1:0] run_cnt;
  logic             run_done;
  logic             tec_zero;
  logic             rec_finish;

  assign run_hold   = ~busoff_flag | sw_reset_mode | busoff_set;
  assign rec_finish = recovery_done(busoff_flag, run_done, tec_zero);

  can_bor_run_det #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (run_hold),
    .bit_valid(rx_bit_valid),
    .bus_bit  (rx_bit),
    .run_cnt  (run_cnt),
    .run_done (run_done)
  );

  can_bor_tec #(.TEC_W(TEC_W), .TEC_START(TEC_START)) u_tec (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_start(busoff_set),
    .in_busoff (busoff_flag),
    .step      (run_done),
    .tec_in    (tec_in),
    .tec_q     (tec_out),
    .at_zero   (tec_zero)
  );

  can_bor_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (busoff_set),
    .done_evt(rec_finish),
    .busoff_q(busoff_flag),
    .warn_q  (warn_irq)
  );

endmodule

// File: rtl/can_busoff_recovery_chk.sv
module can_busoff_recovery_chk #(
  parameter int unsigned RUN_LEN   = 11,
  parameter int unsigned TEC_W     = 9,
  parameter int unsigned TEC_START = 127,
  localparam int unsigned RUN_W    = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busoff_set,
  input logic             sw_reset_mode,
  input logic [TEC_W-1:0] tec_in,
  input logic [TEC_W-1:0] tec_out,
  input logic             busoff_flag,
  input logic             warn_irq,
  input logic [RUN_W-1:0] run_cnt,
  input logic             run_done,
  input logic             rec_finish
);

  AST_ENTRY_LOADS_START: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_set |=> (busoff_flag && tec_out == TEC_W'(TEC_START))); // R2

  AST_RESET_MODE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff_flag && sw_reset_mode && !busoff_set) |=> (tec_out == $past(tec_out))); // R3

  AST_RUN_NEEDS_OPERATE: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |-> (busoff_flag && !sw_reset_mode)); // R4

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff_flag && !busoff_set) |=>
      ((tec_out == $past(tec_out)) || (tec_out == $past(tec_out) - 1'b1))); // R4

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_flag |-> (run_cnt < RUN_W'(RUN_LEN))); // R6

  AST_FINISH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rec_finish |=> (!busoff_flag && warn_irq)); // R7

  AST_WARN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq |=> !warn_irq); // R8

  AST_FLAG_FALL_WARNS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busoff_flag) |-> warn_irq); // R8

  AST_IDLE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busoff_flag && !busoff_set) |=> (tec_out == $past(tec_in))); // R9

endmodule

bind can_busoff_recovery can_busoff_recovery_chk #(
  .RUN_LEN(RUN_LEN), .TEC_W(TEC_W), .TEC_START(TEC_START)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busoff_set   (busoff_set),
  .sw_reset_mode(sw_reset_mode),
  .tec_in       (tec_in),
  .tec_out      (tec_out),
  .busoff_flag  (busoff_flag),
  .warn_irq     (warn_irq),
  .run_cnt      (run_cnt),
  .run_done     (run_done),
  .rec_finish   (rec_finish)
);

// File: tb/test_can_busoff_recovery.sv
module test_can_busoff_recovery;

  localparam int CLK_PERIOD = 10;
  localparam int TEC_W      = 9;
  localparam int RUN_LEN    = 11;
  localparam int TEC_START  = 127;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_bit_valid = 1'b0;
  logic             rx_bit = 1'b0;
  logic             busoff_set = 1'b0;
  logic             sw_reset_mode = 1'b1;
  logic [TEC_W-1:0] tec_in = '0;
  logic [TEC_W-1:0] tec_out;
  logic             busoff_flag;
  logic             warn_irq;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_busoff_recovery i_can_busoff_recovery (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_bit_valid (rx_bit_valid),
    .rx_bit       (rx_bit),
    .busoff_set   (busoff_set),
    .sw_reset_mode(sw_reset_mode),
    .tec_in       (tec_in),
    .tec_out      (tec_out),
    .busoff_flag  (busoff_flag),
    .warn_irq     (warn_irq)
  );

  // Behavioural reference, written from the requirements.
  int m_tec = 0;
  int m_run = 0;
  bit m_busoff = 0;
  bit m_warn = 0;

  function automatic int ref_tec_after_run(int t);
    return (t > 0) ? t - 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tec <= 0; m_run <= 0; m_busoff <= 0; m_warn <= 0;
    end else begin
      m_warn <= 0;
      if (busoff_set) begin
        m_busoff <= 1; m_tec <= TEC_START; m_run <= 0;
      end else if (!m_busoff) begin
        m_tec <= int'(tec_in); m_run <= 0;
      end else if (sw_reset_mode) begin
        m_run <= 0;
      end else if (rx_bit_valid) begin
        if (!rx_bit) m_run <= 0;
        else if (m_run + 1 == RUN_LEN) begin
          m_run <= 0;
          if (m_tec == 0) begin m_busoff <= 0; m_warn <= 1; end
          else m_tec <= ref_tec_after_run(m_tec);
        end else m_run <= m_run + 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk(m_busoff ? "R4" : "R9", "tec_out vs model", int'(tec_out), m_tec);
    chk("R7", "busoff_flag vs model", int'(busoff_flag), int'(m_busoff));
    chk("R8", "warn_irq vs model", int'(warn_irq), int'(m_warn));
  endtask

  task automatic cyc(input logic v, input logic b);
    rx_bit_valid = v;
    rx_bit = b;
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1);
  endtask

  task automatic enter();
    busoff_set = 1'b1;
    cyc(1'b1, 1'b1);
    busoff_set = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL R7 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "tec_out at reset", int'(tec_out), 0);
    chk("R1", "busoff_flag at reset", int'(busoff_flag), 0);
    chk("R1", "warn_irq at reset", int'(warn_irq), 0);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0);

    // R2: entry loads start value
    sw_reset_mode = 1'b1;
    enter();
    chk("R2", "tec after entry", int'(tec_out), 127);
    chk("R2", "flag after entry", int'(busoff_flag), 1);

    // R3: reset mode freezes recovery
    ones(30);
    chk("R3", "tec held in reset mode", int'(tec_out), 127);

    // R5: invalid cycles ignored inside a run
    sw_reset_mode = 1'b0;
    ones(10);
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
    chk("R5", "no step before 11th", int'(tec_out), 127);
    ones(1);
    chk("R5", "invalid samples do not break run", int'(tec_out), 126);

    // R5: valid dominant restarts run; R4: eleven give one step
    ones(10);
    cyc(1'b1, 1'b0);
    ones(10);
    chk("R5", "dominant restarts run", int'(tec_out), 126);
    ones(1);
    chk("R4", "eleven recessive step", int'(tec_out), 125);

    // R6: no overlapping counts
    ones(22);
    chk("R6", "22 recessive give two", int'(tec_out), 123);
    ones(21);
    chk("R6", "21 recessive give one", int'(tec_out), 122);
    cyc(1'b1, 1'b0);

    // R3: reset-mode cycle discards partial run
    ones(10);
    sw_reset_mode = 1'b1;
    cyc(1'b1, 1'b1);
    sw_reset_mode = 1'b0;
    ones(1);
    chk("R3", "partial run discarded", int'(tec_out), 122);
    ones(10);
    chk("R3", "fresh run counted", int'(tec_out), 121);

    // R2: re-entry during recovery restarts
    ones(5);
    enter();
    chk("R2", "re-entry reload", int'(tec_out), 127);
    ones(10);
    chk("R2", "partial run dropped on entry", int'(tec_out), 127);

    // R7/R8: full drain from fresh entry
    enter();
    ones(1407);
    chk("R7", "tec reaches zero", int'(tec_out), 0);
    chk("R7", "still bus-off before 128th", int'(busoff_flag), 1);
    chk("R8", "no warn early", int'(warn_irq), 0);
    ones(1);
    chk("R7", "flag clears by itself", int'(busoff_flag), 0);
    chk("R8", "warn pulse", int'(warn_irq), 1);
    cyc(1'b0, 1'b0);
    chk("R8", "warn one cycle only", int'(warn_irq), 0);

    // R9: pass-through outside bus-off
    for (int i = 0; i < 12; i++) begin
      int v;
      v = int'($urandom % 512);
      tec_in = TEC_W'(v);
      cyc(1'b1, 1'b1);
      chk("R9", "tec follows tec_in", int'(tec_out), v);
      chk("R9", "no bus-off from stream", int'(busoff_flag), 0);
    end

    // Constrained random
    for (int i = 0; i < 6000; i++) begin
      busoff_set = (($urandom % 800) == 0);
      if (($urandom % 200) == 0) sw_reset_mode = ~sw_reset_mode;
      tec_in = TEC_W'($urandom % 512);
      cyc((($urandom % 4) != 0), (($urandom % 16) != 0));
      busoff_set = 1'b0;
    end

    finish_run();
  end

endmodule